// File: doc/BRIEF.md
# Parallel NOR Flash Command Front End

This block models the control side of a parallel NOR flash part around a small on-chip cell array. It watches active-low chip select, read strobe and write strobe pins together with a width-select pin. Each write strobe pulse feeds a command sequencer. The sequencer unlocks, programs, erases and identifies the part. Each read strobe returns either array contents, a busy status byte or an identification byte. The data bus is split into an input vector, an output vector and a per-line drive enable, so a pad ring outside the block can build the tristate bus.

Program and erase complete after fixed, parameterised cycle counts. A per-sector lock input guards sectors against change. A fast-program input forces the short two-write program mode and lifts all locks while it is held. Command addresses are word addresses in both bus widths.

Top module: `nor_flash_front`

States: `ST_READ` (idle, array reads), `ST_UNL1` / `ST_UNL2` (first and second unlock writes seen), `ST_PGM_DATA` (waiting for program data), `ST_ERS_A` / `ST_ERS_B` / `ST_ERS_C` (erase unlock repeats and erase select), `ST_ERS_COLL` (gathering sectors), `ST_AUTOSEL` (identification reads), `ST_BYP_PGM` (bypass program data), `ST_BYP_EXIT` (bypass leave armed), `ST_BUSY` (program or erase running).

Transitions:
- Unlock: `ST_READ`→`ST_UNL1` on 0xAA@0x555, then →`ST_UNL2` on 0x55@0x2AA.
- From `ST_UNL2`, writes to 0x555: 0xA0→`ST_PGM_DATA`, 0x80→`ST_ERS_A`, 0x90→`ST_AUTOSEL`, 0x20→`ST_READ` with bypass set.
- Program data: `ST_PGM_DATA` or `ST_BYP_PGM`→`ST_BUSY` on the data write.
- Erase unlock: `ST_ERS_A`→`ST_ERS_B` on 0xAA@0x555, →`ST_ERS_C` on 0x55@0x2AA.
- Erase select: `ST_ERS_C`→`ST_BUSY` on 0x10@0x555 (whole array), or →`ST_ERS_COLL` on 0x30 (sector).
- Sector gathering: `ST_ERS_COLL`→`ST_BUSY` when its window expires.
- Bypass, in `ST_READ`: 0xA0→`ST_BYP_PGM`, 0x90→`ST_BYP_EXIT`. Then `ST_BYP_EXIT`→`ST_READ`; a 0x00 write clears bypass.
- `ST_BUSY`→`ST_READ` when its count runs out.
- Abort: any wrong cycle → `ST_READ`.

## Requirements
- R1: After reset the sequencer is in `ST_READ` with bypass off, every array word reads 0xFFFF, and array reads work with no command.
- R2: A read cycle (ce_n=0, oe_n=0, we_n=1) drives the word at `addr` on all 16 lines (dq_oe=0xFFFF) in word mode. When ce_n=1, oe_n=1 or we_n=0, dq_oe is 0.
- R3: A command write is ce_n=0, we_n=0, oe_n=1. A strobe held low for several clocks counts as one write, and a write attempted with oe_n=0 is ignored.
- R4: With byte_n=0, only lines 7..0 are driven (dq_oe=0x00FF). dq_in[15] is the byte address bit: 1 selects bits 15..8 of the word, 0 selects bits 7..0. Program data on dq_in[7:0] goes to that byte.
- R5: The program sequence is 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then data@addr. The new word is the old word AND the data.
- R6: 0x20@0x555 after the two unlock writes enters bypass. In bypass, 0xA0 then data programs. 0x90 then 0x00 leaves bypass, after which 0xA0 plus data changes nothing.
- R7: While acc=1 the part acts as in bypass and locked sectors can be programmed and erased. After acc returns to 0, a bare 0xA0 plus data changes nothing.
- R8: A sector whose lock_mask bit is 1 is unchanged by program and erase while acc=0. The sector is `addr[5:4]`.
- R9: After 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA: 0x10@0x555 erases all unlocked sectors. 0x30@addr selects that address's sector. Each further 0x30 within SECT_WIN cycles adds a sector. Erasure starts SECT_WIN cycles after the last 0x30. Unselected sectors keep their data.
- R10: For PROG_CYC (program) or ERASE_CYC (erase) cycles after the start, reads return a status byte on lines 7..0 only. Bit 7 is 0 and bit 6 inverts after every read. Command writes during that time are ignored.
- R11: After 0xAA@0x555, 0x55@0x2AA, 0x90@0x555, reads return a byte on lines 7..0 only. addr[1:0]=00 gives MFR_ID, 01 gives DEV_ID, and 10 gives the lock bit of sector addr[5:4] in bit 0.
- R12: 0xF0 written at any address, except in `ST_BUSY` or a program data cycle, returns to `ST_READ`. A wrong unlock cycle also returns to `ST_READ`, so a following 0xA0 plus data programs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| byte_n | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| acc | input | 1 | Fast-program force, active high |
| lock_mask | input | NSECT | Per-sector lock, 1 = locked |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data lines into the part |
| dq_out | output | 16 | Data lines out of the part |
| dq_oe | output | 16 | Per-line drive enable |

## Verification
A read result is combinational, so the bench samples it 1 ns after the negedge where the read strobe goes low. A command write takes effect at the first posedge with the strobe low. The busy window opens at that same edge and lasts PROG_CYC or ERASE_CYC edges, so status reads are placed within a few cycles of the data write. Array reads are placed well after the window has closed. The status toggle flips at the posedge after a read ends, so each read task idles one cycle before returning. Sector erase starts SECT_WIN edges after the last select write, so the erase status is read only after that delay.

// File: rtl/nor_pkg.sv
package nor_pkg;
    typedef enum logic [3:0] {
        ST_READ, ST_UNL1, ST_UNL2, ST_PGM_DATA,
        ST_ERS_A, ST_ERS_B, ST_ERS_C, ST_ERS_COLL,
        ST_AUTOSEL, ST_BYP_PGM, ST_BYP_EXIT, ST_BUSY
    } nor_state_t;

    localparam logic [7:0]  CMD_UNL_A   = 8'hAA;
    localparam logic [7:0]  CMD_UNL_B   = 8'h55;
    localparam logic [7:0]  CMD_PROG    = 8'hA0;
    localparam logic [7:0]  CMD_ERASE   = 8'h80;
    localparam logic [7:0]  CMD_IDENT   = 8'h90;
    localparam logic [7:0]  CMD_BYPASS  = 8'h20;
    localparam logic [7:0]  CMD_CHIP    = 8'h10;
    localparam logic [7:0]  CMD_SECT    = 8'h30;
    localparam logic [7:0]  CMD_ABORT   = 8'hF0;
    localparam logic [7:0]  CMD_BYP_END = 8'h00;
    localparam logic [15:0] ADR_UNL_A   = 16'h0555;
    localparam logic [15:0] ADR_UNL_B   = 16'h02AA;
endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int ARR_AW    = 6,
    parameter int SECT_W    = 2,
    parameter int PROG_CYC  = 12,
    parameter int ERASE_CYC = 24,
    parameter int SECT_WIN  = 6,
    localparam int NSECT    = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_cmd,
    input  logic              acc,
    output nor_state_t        st_o,
    output logic              pgm_go,
    output logic              ers_go,
    output logic [NSECT-1:0]  ers_mask
);
    localparam int MAXC1 = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int MAXC  = (MAXC1 > SECT_WIN) ? MAXC1 : SECT_WIN;
    localparam int CNT_W = $clog2(MAXC + 1);

    nor_state_t       st_q, st_n;
    logic             byp_q, byp_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [NSECT-1:0] smask_q, smask_n;

    logic             in_byp, at_a, at_b, is_a1, is_a2;
    logic [NSECT-1:0] sect_hot;

    assign in_byp   = byp_q | acc;
    assign at_a     = (wr_addr == ADR_UNL_A[ADDR_W-1:0]);
    assign at_b     = (wr_addr == ADR_UNL_B[ADDR_W-1:0]);
    assign is_a1    = at_a && (wr_cmd == CMD_UNL_A);
    assign is_a2    = at_b && (wr_cmd == CMD_UNL_B);
    assign sect_hot = NSECT'(1) << wr_addr[ARR_AW-1 -: SECT_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_READ;
            byp_q   <= 1'b0;
            cnt_q   <= '0;
            smask_q <= '0;
        end else begin
            st_q    <= st_n;
            byp_q   <= byp_n;
            cnt_q   <= cnt_n;
            smask_q <= smask_n;
        end
    end

    // next state
    always_comb begin
        st_n    = st_q;
        byp_n   = byp_q;
        cnt_n   = cnt_q;
        smask_n = smask_q;
        unique case (st_q)
            ST_READ: if (wr_pulse) begin
                if (in_byp && wr_cmd == CMD_PROG)       st_n = ST_BYP_PGM;
                else if (in_byp && wr_cmd == CMD_IDENT) st_n = ST_BYP_EXIT;
                else if (!in_byp && is_a1)              st_n = ST_UNL1;
            end
            ST_UNL1: if (wr_pulse) st_n = is_a2 ? ST_UNL2 : ST_READ;
            ST_UNL2: if (wr_pulse) begin
                st_n = ST_READ;
                if (at_a) begin
                    if (wr_cmd == CMD_PROG)        st_n = ST_PGM_DATA;
                    else if (wr_cmd == CMD_ERASE)  st_n = ST_ERS_A;
                    else if (wr_cmd == CMD_IDENT)  st_n = ST_AUTOSEL;
                    else if (wr_cmd == CMD_BYPASS) byp_n = 1'b1;
                end
            end
            ST_PGM_DATA, ST_BYP_PGM: if (wr_pulse) begin
                st_n  = ST_BUSY;
                cnt_n = CNT_W'(PROG_CYC - 1);
            end
            ST_ERS_A: if (wr_pulse) st_n = is_a1 ? ST_ERS_B : ST_READ;
            ST_ERS_B: if (wr_pulse) st_n = is_a2 ? ST_ERS_C : ST_READ;
            ST_ERS_C: if (wr_pulse) begin
                if (at_a && wr_cmd == CMD_CHIP) begin
                    st_n  = ST_BUSY;
                    cnt_n = CNT_W'(ERASE_CYC - 1);
                end else if (wr_cmd == CMD_SECT) begin
                    st_n    = ST_ERS_COLL;
                    smask_n = sect_hot;
                    cnt_n   = CNT_W'(SECT_WIN - 1);
                end else begin
                    st_n = ST_READ;
                end
            end
            ST_ERS_COLL: begin
                if (wr_pulse) begin
                    if (wr_cmd == CMD_SECT) begin
                        smask_n = smask_q | sect_hot;
                        cnt_n   = CNT_W'(SECT_WIN - 1);
                    end else begin
                        st_n    = ST_READ;
                        smask_n = '0;
                    end
                end else if (cnt_q == '0) begin
                    st_n    = ST_BUSY;
                    smask_n = '0;
                    cnt_n   = CNT_W'(ERASE_CYC - 1);
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            ST_AUTOSEL: ;
            ST_BYP_EXIT: if (wr_pulse) begin
                st_n = ST_READ;
                if (wr_cmd == CMD_BYP_END) byp_n = 1'b0;
            end
            ST_BUSY: begin
                if (cnt_q == '0) st_n = ST_READ;
                else             cnt_n = cnt_q - 1'b1;
            end
            default: st_n = ST_READ;
        endcase
        if (wr_pulse && wr_cmd == CMD_ABORT &&
            !(st_q inside {ST_BUSY, ST_PGM_DATA, ST_BYP_PGM})) begin
            st_n    = ST_READ;
            smask_n = '0;
        end
    end

    // outputs
    always_comb begin
        st_o     = st_q;
        pgm_go   = wr_pulse && (st_q inside {ST_PGM_DATA, ST_BYP_PGM});
        ers_go   = ((st_q == ST_ERS_C) && wr_pulse && at_a && wr_cmd == CMD_CHIP) ||
                   ((st_q == ST_ERS_COLL) && !wr_pulse && cnt_q == '0);
        ers_mask = (st_q == ST_ERS_C) ? '1 : smask_q;
    end
endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
    parameter int ARR_AW  = 6,
    parameter int SECT_W  = 2,
    localparam int NWORDS = 1 << ARR_AW,
    localparam int NSECT  = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_go,
    input  logic [ARR_AW-1:0] pgm_idx,
    input  logic [15:0]       pgm_word,
    input  logic              ers_go,
    input  logic [NSECT-1:0]  ers_mask,
    input  logic [NSECT-1:0]  lock_mask,
    input  logic              unlock_all,
    input  logic [ARR_AW-1:0] rd_idx,
    output logic [15:0]       rd_word
);
    logic [15:0]      cells [NWORDS];
    logic [NSECT-1:0] open_mask;

    assign open_mask = unlock_all ? '1 : ~lock_mask;
    assign rd_word   = cells[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NWORDS; w++) cells[w] <= 16'hFFFF;
        end else if (ers_go) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (ers_mask[w >> (ARR_AW - SECT_W)] && open_mask[w >> (ARR_AW - SECT_W)])
                    cells[w] <= 16'hFFFF;
            end
        end else if (pgm_go && open_mask[pgm_idx[ARR_AW-1 -: SECT_W]]) begin
            cells[pgm_idx] <= cells[pgm_idx] & pgm_word;
        end
    end
endmodule

// File: rtl/nor_read_path.sv
module nor_read_path #(
    parameter logic [7:0] MFR_ID = 8'h5A,
    parameter logic [7:0] DEV_ID = 8'hC3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic        busy,
    input  logic        ident,
    input  logic        byte_mode,
    input  logic        a_lsb,
    input  logic [1:0]  id_sel,
    input  logic        lock_bit,
    input  logic [15:0] arr_word,
    output logic [15:0] dq_out,
    output logic [15:0] dq_oe
);
    logic rd_q, tog_q;
    logic [7:0] id_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= 1'b0;
            tog_q <= 1'b0;
        end else begin
            rd_q <= rd_en;
            if (busy && rd_q && !rd_en) tog_q <= ~tog_q;
        end
    end

    always_comb begin
        unique case (id_sel)
            2'b00:   id_byte = MFR_ID;
            2'b01:   id_byte = DEV_ID;
            2'b10:   id_byte = {7'b0, lock_bit};
            default: id_byte = 8'h00;
        endcase
    end

    always_comb begin
        dq_out = '0;
        dq_oe  = '0;
        if (rd_en) begin
            if (busy) begin
                dq_out = {8'h00, 1'b0, tog_q, 6'b0};
                dq_oe  = 16'h00FF;
            end else if (ident) begin
                dq_out = {8'h00, id_byte};
                dq_oe  = 16'h00FF;
            end else if (byte_mode) begin
                dq_out = {8'h00, a_lsb ? arr_word[15:8] : arr_word[7:0]};
                dq_oe  = 16'h00FF;
            end else begin
                dq_out = arr_word;
                dq_oe  = 16'hFFFF;
            end
        end
    end
endmodule

// File: rtl/nor_flash_front.sv
module nor_flash_front
    import nor_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int ARR_AW       = 6,
    parameter int SECT_W       = 2,
    parameter int PROG_CYC     = 12,
    parameter int ERASE_CYC    = 24,
    parameter int SECT_WIN     = 6,
    parameter logic [7:0] MFR_ID = 8'h5A,
    parameter logic [7:0] DEV_ID = 8'hC3,
    localparam int NSECT       = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              byte_n,
    input  logic              acc,
    input  logic [NSECT-1:0]  lock_mask,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe
);
    logic             wr_cond, wr_q, wr_pulse, rd_cond;
    logic [7:0]       cmd;
    logic [15:0]      pgm_word, arr_word;
    logic             pgm_go, ers_go;
    logic [NSECT-1:0] ers_mask;
    nor_state_t       st;

    assign wr_cond  = !ce_n && !we_n && oe_n;
    assign rd_cond  = !ce_n && !oe_n && we_n;
    assign wr_pulse = wr_cond && !wr_q;
    assign cmd      = dq_in[7:0];
    assign pgm_word = byte_n ? dq_in :
                      (dq_in[15] ? {dq_in[7:0], 8'hFF} : {8'hFF, dq_in[7:0]});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= 1'b0;
        else        wr_q <= wr_cond;
    end

    nor_cmd_fsm #(
        .ADDR_W(ADDR_W), .ARR_AW(ARR_AW), .SECT_W(SECT_W),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .SECT_WIN(SECT_WIN)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_addr(addr),
        .wr_cmd(cmd), .acc(acc), .st_o(st), .pgm_go(pgm_go),
        .ers_go(ers_go), .ers_mask(ers_mask)
    );

    nor_cell_array #(.ARR_AW(ARR_AW), .SECT_W(SECT_W)) arr_i (
        .clk(clk), .rst_n(rst_n), .pgm_go(pgm_go), .pgm_idx(addr[ARR_AW-1:0]),
        .pgm_word(pgm_word), .ers_go(ers_go), .ers_mask(ers_mask),
        .lock_mask(lock_mask), .unlock_all(acc), .rd_idx(addr[ARR_AW-1:0]),
        .rd_word(arr_word)
    );

    nor_read_path #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) rdp_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_cond), .busy(st == ST_BUSY),
        .ident(st == ST_AUTOSEL), .byte_mode(!byte_n), .a_lsb(dq_in[15]),
        .id_sel(addr[1:0]), .lock_bit(lock_mask[addr[ARR_AW-1 -: SECT_W]]),
        .arr_word(arr_word), .dq_out(dq_out), .dq_oe(dq_oe)
    );
endmodule

// File: rtl/nor_flash_front_chk.sv
module nor_flash_front_chk
    import nor_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        ce_n,
    input logic        oe_n,
    input logic        we_n,
    input logic        byte_n,
    input logic        acc,
    input logic [15:0] dq_oe,
    input nor_state_t  st,
    input logic        wr_pulse,
    input logic [7:0]  cmd
);
    logic rd;
    assign rd = !ce_n && !oe_n && we_n;

    AST_RESET_TO_READ: assert property (@(posedge clk) !rst_n |=> st == ST_READ); // R1
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n) !rd |-> dq_oe == 16'h0000); // R2
    AST_BYTE_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n) !byte_n |-> dq_oe[15:8] == 8'h00); // R4
    AST_ACC_BYPASS: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_READ && acc && wr_pulse && cmd == CMD_PROG) |=> st == ST_BYP_PGM); // R7
    AST_BUSY_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_BUSY && rd) |-> dq_oe == 16'h00FF); // R10
    AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_BUSY && wr_pulse) |=> (st == ST_BUSY || st == ST_READ)); // R10
    AST_ID_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_AUTOSEL && rd) |-> dq_oe == 16'h00FF); // R11
endmodule

bind nor_flash_front nor_flash_front_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .byte_n(byte_n), .acc(acc), .dq_oe(dq_oe), .st(st),
    .wr_pulse(wr_pulse), .cmd(cmd)
);

// File: tb/nor_flash_front_tb.sv
`timescale 1ns/1ps
module nor_flash_front_tb_top;
    localparam int PROG_CYC  = 12;
    localparam int ERASE_CYC = 24;
    localparam int SECT_WIN  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, byte_n = 1'b1, acc = 1'b0;
    logic [3:0]  lock_mask = 4'b0010;
    logic [10:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out, dq_oe;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    nor_flash_front dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .byte_n(byte_n), .acc(acc), .lock_mask(lock_mask), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [15:0] d, input int hold = 1, input logic oe = 1'b1);
        @(negedge clk);
        addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe;
        repeat (hold) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [10:0] a, input logic lsb, output logic [15:0] d, output logic [15:0] oe);
        @(negedge clk);
        addr = a; dq_in = {lsb, 15'h0}; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1 d = dq_out; oe = dq_oe;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock();
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
    endtask

    task automatic prog(input logic [10:0] a, input logic [15:0] d);
        unlock();
        wr(11'h555, 16'h00A0);
        wr(a, d);
        repeat (PROG_CYC + 4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d, oe;
        chk("R2 idle bus", dq_oe, 16'h0000);
        rd(11'd5, 1'b0, d, oe);
        chk("R1 erased word", d, 16'hFFFF);
        chk("R2 word lanes", oe, 16'hFFFF);
    endtask

    task automatic t_program();
        logic [15:0] d1, o1, d2, o2, d;
        unlock();
        wr(11'h555, 16'h00A0);
        wr(11'd3, 16'h1234);
        rd(11'd3, 1'b0, d1, o1);
        rd(11'd3, 1'b0, d2, o2);
        chk("R10 status lanes", o1, 16'h00FF);
        chk("R10 status bit7", {15'h0, d1[7]}, 16'h0);
        chk("R10 bit6 toggles", {15'h0, d2[6]}, {15'h0, ~d1[6]});
        repeat (PROG_CYC + 4) @(negedge clk);
        rd(11'd3, 1'b0, d, o1);
        chk("R5 programmed", d, 16'h1234);
        prog(11'd3, 16'hFF00);
        rd(11'd3, 1'b0, d, o1);
        chk("R5 and with old", d, 16'h1200);
    endtask

    task automatic t_strobe();
        logic [15:0] d, o;
        wr(11'h555, 16'h00AA, 3);
        wr(11'h2AA, 16'h0055);
        wr(11'h555, 16'h00A0);
        wr(11'd10, 16'h00F0);
        repeat (PROG_CYC + 4) @(negedge clk);
        rd(11'd10, 1'b0, d, o);
        chk("R3 held strobe once", d, 16'h00F0);
        wr(11'h555, 16'h00AA, 1, 1'b0);
        wr(11'h2AA, 16'h0055);
        wr(11'h555, 16'h00A0);
        wr(11'd11, 16'h0000);
        repeat (PROG_CYC + 4) @(negedge clk);
        rd(11'd11, 1'b0, d, o);
        chk("R3 write with oe low ignored", d, 16'hFFFF);
    endtask

    task automatic t_abort();
        logic [15:0] d, o;
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0056);
        wr(11'h555, 16'h00A0);
        wr(11'd12, 16'h0000);
        repeat (PROG_CYC + 4) @(negedge clk);
        rd(11'd12, 1'b0, d, o);
        chk("R12 wrong unlock", d, 16'hFFFF);
        wr(11'h555, 16'h00AA);
        wr(11'h123, 16'h00F0);
        wr(11'h2AA, 16'h0055);
        wr(11'h555, 16'h00A0);
        wr(11'd12, 16'h0000);
        repeat (PROG_CYC + 4) @(negedge clk);
        rd(11'd12, 1'b0, d, o);
        chk("R12 abort mid sequence", d, 16'hFFFF);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] d, o;
        unlock();
        wr(11'h555, 16'h00A0);
        wr(11'd13, 16'hBEEF);
        wr(11'h555, 16'h00AA);
        repeat (PROG_CYC + 4) @(negedge clk);
        wr(11'h2AA, 16'h0055);
        wr(11'h555, 16'h00A0);
        wr(11'd13, 16'h0000);
        repeat (PROG_CYC + 4) @(negedge clk);
        rd(11'd13, 1'b0, d, o);
        chk("R10 write during busy ignored", d, 16'hBEEF);
    endtask

    task automatic t_byte();
        logic [15:0] d, o;
        byte_n = 1'b0;
        rd(11'd3, 1'b1, d, o);
        chk("R4 upper byte", d[7:0], 16'h0012);
        chk("R4 byte lanes", o, 16'h00FF);
        rd(11'd3, 1'b0, d, o);
        chk("R4 lower byte", d[7:0], 16'h0000);
        unlock();
        wr(11'h555, 16'h00A0);
        wr(11'd7, 16'h803C);
        repeat (PROG_CYC + 4) @(negedge clk);
        byte_n = 1'b1;
        rd(11'd7, 1'b0, d, o);
        chk("R4 byte program", d, 16'h3CFF);
    endtask

    task automatic t_bypass();
        logic [15:0] d, o;
        unlock();
        wr(11'h555, 16'h0020);
        wr(11'd9, 16'h00A0);
        wr(11'd9, 16'hA5A5);
        repeat (PROG_CYC + 4) @(negedge clk);
        rd(11'd9, 1'b0, d, o);
        chk("R6 bypass program", d, 16'hA5A5);
        wr(11'd0, 16'h0090);
        wr(11'd0, 16'h0000);
        wr(11'd14, 16'h00A0);
        wr(11'd14, 16'h0000);
        repeat (PROG_CYC + 4) @(negedge clk);
        rd(11'd14, 1'b0, d, o);
        chk("R6 bypass left", d, 16'hFFFF);
    endtask

    task automatic t_acc();
        logic [15:0] d, o;
        acc = 1'b1;
        wr(11'd17, 16'h00A0);
        wr(11'd17, 16'h0F0F);
        repeat (PROG_CYC + 4) @(negedge clk);
        acc = 1'b0;
        rd(11'd17, 1'b0, d, o);
        chk("R7 acc programs locked", d, 16'h0F0F);
        wr(11'd15, 16'h00A0);
        wr(11'd15, 16'h0000);
        repeat (PROG_CYC + 4) @(negedge clk);
        rd(11'd15, 1'b0, d, o);
        chk("R7 acc released", d, 16'hFFFF);
        prog(11'd19, 16'h0000);
        rd(11'd19, 1'b0, d, o);
        chk("R8 locked program", d, 16'hFFFF);
    endtask

    task automatic erase_setup();
        unlock();
        wr(11'h555, 16'h0080);
        unlock();
    endtask

    task automatic t_erase();
        logic [15:0] d, o, d1, d2, o1;
        prog(11'd40, 16'h0000);
        prog(11'd50, 16'h0000);
        erase_setup();
        wr(11'd3, 16'h0030);
        wr(11'd17, 16'h0030);
        wr(11'd40, 16'h0030);
        repeat (SECT_WIN + 1) @(negedge clk);
        rd(11'd3, 1'b0, d1, o1);
        rd(11'd3, 1'b0, d2, o1);
        chk("R10 erase status toggles", {15'h0, d2[6]}, {15'h0, ~d1[6]});
        repeat (ERASE_CYC + 4) @(negedge clk);
        rd(11'd3, 1'b0, d, o);
        chk("R9 sector 0 erased", d, 16'hFFFF);
        rd(11'd40, 1'b0, d, o);
        chk("R9 sector 2 erased", d, 16'hFFFF);
        rd(11'd50, 1'b0, d, o);
        chk("R9 sector 3 kept", d, 16'h0000);
        rd(11'd17, 1'b0, d, o);
        chk("R8 locked sector kept", d, 16'h0F0F);
        erase_setup();
        wr(11'h555, 16'h0010);
        repeat (ERASE_CYC + 4) @(negedge clk);
        rd(11'd50, 1'b0, d, o);
        chk("R9 chip erase", d, 16'hFFFF);
        rd(11'd17, 1'b0, d, o);
        chk("R8 chip erase skips lock", d, 16'h0F0F);
    endtask

    task automatic t_ident();
        logic [15:0] d, o;
        unlock();
        wr(11'h555, 16'h0090);
        rd(11'd0, 1'b0, d, o);
        chk("R11 maker code", d, 16'h005A);
        chk("R11 id lanes", o, 16'h00FF);
        rd(11'd1, 1'b0, d, o);
        chk("R11 device code", d, 16'h00C3);
        rd(11'd18, 1'b0, d, o);
        chk("R11 locked sector", d, 16'h0001);
        rd(11'd34, 1'b0, d, o);
        chk("R11 open sector", d, 16'h0000);
        wr(11'd0, 16'h00F0);
        rd(11'd17, 1'b0, d, o);
        chk("R12 abort leaves ident", d, 16'h0F0F);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_strobe();
        t_abort();
        t_busy_ignore();
        t_byte();
        t_bypass();
        t_acc();
        t_erase();
        t_ident();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule